// File: doc/BRIEF.md
# Periodic Logic-Block Repair Sequencer

This controller watches over eight logic blocks built from drift-prone resistive devices. A programmable period timer starts a sweep. The sweep visits the logic blocks in order 0 to 7. For each block it asks an external measurement driver for a 12-bit resistance code at the block's current physical location. It then tests that code against an inclusive window given by two bound inputs.

A block whose code falls outside the window does not get a spare at once. It goes through a fixed chain of recovery steps:
1. A resistance adjustment.
2. A re-measurement.
3. If that re-measurement still fails, a stronger over-reset repair.
4. A final re-check measurement.

A block that fails the re-check is taken out of service. Its entry in the remap table is pointed at the next unused spare (physical indices 8 to 11). Once all four spares are used, a sticky fault flag is raised instead. Each external operation is a request/done handshake. A done that does not arrive within `TIMEOUT` cycles counts as a failure of that step.

States and transitions:
- **IDLE**: goes to MEAS on a period tick, starting at block 0.
- **MEAS**: a pass goes to NEXT. A fail or a timeout goes to ADJ.
- **ADJ**: a done goes to REMEAS. A timeout goes to REPAIR.
- **REMEAS**: a pass goes to NEXT. A fail or a timeout goes to REPAIR.
- **REPAIR**: a done goes to RECHECK. A timeout goes to REPLACE.
- **RECHECK**: a pass goes to NEXT. A fail or a timeout goes to REPLACE.
- **REPLACE**: always goes to NEXT.
- **NEXT**: after block 7 it goes to IDLE. Otherwise it goes to MEAS for the following block.

Top module: `lrs_repair_seq`

## Requirements
- R1: A free-running cycle counter produces a tick every `period` cycles: the counter clears on the tick and counts 0 to `period`-1. A tick seen in IDLE starts a sweep, and `sweep_busy` rises the next cycle. A `period` of 0 produces no ticks.
- R2: A tick that arrives while a sweep is in progress is dropped. A new sweep starts only from IDLE, and no request is raised while `sweep_busy` is low.
- R3: A sweep visits logic blocks 0 to 7 in order, with at most one request high at a time. A measurement code c passes when `win_lo` <= c <= `win_hi`, with both bounds included. A pass moves on to the next block.
- R4: A failing first measurement raises `adj_req`, with `adj_idx` set to the block's physical index.
- R5: When the re-measurement after an adjustment still fails, `rep_req` is raised for that physical index. A failed adjustment step also raises `rep_req`.
- R6: A completed over-reset repair is followed by a re-check measurement. If that re-check passes, the block's remap entry stays unchanged.
- R7: A block that fails its re-check is remapped to the next free spare. Spares are handed out in the order 8, 9, 10, 11. Entry i of `remap_tbl` occupies bits [4i+3:4i], and the table changes only during a sweep.
- R8: When a block fails its re-check and no spare is left, its entry is unchanged and `spare_fault` is set. The flag stays set until reset.
- R9: A request stays high until its done arrives or until `TIMEOUT` cycles have passed. A timeout counts as a failure of that step. Done is honoured only while the matching request is high.
- R10: In later sweeps, a remapped block is measured at its spare's physical index, and its original index is no longer used.
- R11: After reset, no request is high, `sweep_busy` and `spare_fault` are 0, and `remap_tbl` is the identity map (entry i = i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | 16 | Sweep period in cycles; 0 disables |
| win_lo | input | 12 | Inclusive lower bound of the healthy window |
| win_hi | input | 12 | Inclusive upper bound of the healthy window |
| meas_req | output | 1 | Measurement request |
| meas_idx | output | 4 | Physical index to measure |
| meas_done | input | 1 | Measurement complete; `meas_code` is valid |
| meas_code | input | 12 | Measured resistance code |
| adj_req | output | 1 | Resistance adjustment request |
| adj_idx | output | 4 | Physical index to adjust |
| adj_done | input | 1 | Adjustment complete |
| rep_req | output | 1 | Over-reset repair request |
| rep_idx | output | 4 | Physical index to repair |
| rep_done | input | 1 | Repair complete |
| sweep_busy | output | 1 | A sweep is in progress |
| remap_tbl | output | 32 | Active physical index of each logic block, 4 bits per block |
| spare_fault | output | 1 | Sticky: a block failed with no spare left |

## Verification
The measurement path is driven with five patterns, and each exposes a different fault:
- Codes sitting exactly on each window bound show whether the compare is inclusive.
- A block that one adjustment fixes shows whether the chain stops early.
- A block that only the repair fixes shows whether escalation stops before the spare is taken.
- A block that fails every step uses up a spare.
- A block whose drivers never answer reaches replacement purely through timeouts.

Later sweeps with a short period show whether ticks during a sweep are dropped and whether remapped blocks are visited at their spare index. A final sweep that breaks three blocks when only two spares remain separates spare allocation from the exhausted-fault case.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAS,
        ST_ADJ,
        ST_REMEAS,
        ST_REPAIR,
        ST_RECHECK,
        ST_REPLACE,
        ST_NEXT
    } lrs_state_e;

endpackage

// File: rtl/lrs_period_timer.sv
module lrs_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt_q;

    assign tick = (period != '0) && (cnt_q >= (period - ONE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/lrs_window_cmp.sv
module lrs_window_cmp #(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] lo,
    input  logic [CODE_W-1:0] hi,
    output logic              in_win
);
    assign in_win = (code >= lo) && (code <= hi);
endmodule

// File: rtl/lrs_remap_table.sv
module lrs_remap_table #(
    parameter int NUM_BLK   = 8,
    parameter int NUM_SPARE = 4,
    parameter int PIDX_W    = 4,
    parameter int BLK_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BLK_W-1:0]          sel_blk,
    input  logic                      replace,
    output logic [PIDX_W-1:0]         sel_phys,
    output logic [NUM_BLK*PIDX_W-1:0] map_flat,
    output logic                      exhausted_fault
);
    localparam int SP_W = $clog2(NUM_SPARE + 1);

    logic [PIDX_W-1:0] map_q [NUM_BLK];
    logic [SP_W-1:0]   used_q;
    logic              spare_left;

    assign spare_left = (used_q < SP_W'(NUM_SPARE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLK; i++) begin
                map_q[i] <= PIDX_W'(i);
            end
            used_q          <= '0;
            exhausted_fault <= 1'b0;
        end else if (replace) begin
            if (spare_left) begin
                map_q[sel_blk] <= PIDX_W'(NUM_BLK) + PIDX_W'(used_q);
                used_q         <= used_q + SP_W'(1);
            end else begin
                exhausted_fault <= 1'b1;
            end
        end
    end

    assign sel_phys = map_q[sel_blk];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_flat
        assign map_flat[g*PIDX_W +: PIDX_W] = map_q[g];
    end
endmodule

// File: rtl/lrs_repair_seq.sv
module lrs_repair_seq #(
    parameter int NUM_BLK   = 8,
    parameter int NUM_SPARE = 4,
    parameter int CODE_W    = 12,
    parameter int PER_W     = 16,
    parameter int TIMEOUT   = 16,
    localparam int PIDX_W   = $clog2(NUM_BLK + NUM_SPARE),
    localparam int MAP_W    = NUM_BLK * PIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [CODE_W-1:0] win_lo,
    input  logic [CODE_W-1:0] win_hi,
    output logic              meas_req,
    output logic [PIDX_W-1:0] meas_idx,
    input  logic              meas_done,
    input  logic [CODE_W-1:0] meas_code,
    output logic              adj_req,
    output logic [PIDX_W-1:0] adj_idx,
    input  logic              adj_done,
    output logic              rep_req,
    output logic [PIDX_W-1:0] rep_idx,
    input  logic              rep_done,
    output logic              sweep_busy,
    output logic [MAP_W-1:0]  remap_tbl,
    output logic              spare_fault
);
    import lrs_pkg::*;

    localparam int BLK_W  = $clog2(NUM_BLK);
    localparam int WAIT_W = $clog2(TIMEOUT);
    localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(NUM_BLK - 1);
    localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(TIMEOUT - 1);

    lrs_state_e         state_q, state_d;
    logic [BLK_W-1:0]   blk_q;
    logic [WAIT_W-1:0]  wait_q;
    logic               tick, in_win, replace, timed_out, any_req;
    logic [PIDX_W-1:0]  phys;

    lrs_period_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .period(period), .tick(tick)
    );

    lrs_window_cmp #(.CODE_W(CODE_W)) u_cmp (
        .code(meas_code), .lo(win_lo), .hi(win_hi), .in_win(in_win)
    );

    lrs_remap_table #(
        .NUM_BLK(NUM_BLK), .NUM_SPARE(NUM_SPARE), .PIDX_W(PIDX_W), .BLK_W(BLK_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .sel_blk(blk_q), .replace(replace),
        .sel_phys(phys), .map_flat(remap_tbl), .exhausted_fault(spare_fault)
    );

    assign timed_out = (wait_q == WAIT_MAX);

    // Outputs decoded from the current state
    always_comb begin
        meas_req   = 1'b0;
        adj_req    = 1'b0;
        rep_req    = 1'b0;
        replace    = 1'b0;
        sweep_busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_MEAS, ST_REMEAS, ST_RECHECK: meas_req = 1'b1;
            ST_ADJ:                         adj_req  = 1'b1;
            ST_REPAIR:                      rep_req  = 1'b1;
            ST_REPLACE:                     replace  = 1'b1;
            default: ;
        endcase
        meas_idx = phys;
        adj_idx  = phys;
        rep_idx  = phys;
        any_req  = meas_req | adj_req | rep_req;
    end

    // Escalation chain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tick) state_d = ST_MEAS;
            ST_MEAS: begin
                if (meas_done)      state_d = in_win ? ST_NEXT : ST_ADJ;
                else if (timed_out) state_d = ST_ADJ;
            end
            ST_ADJ: begin
                if (adj_done)       state_d = ST_REMEAS;
                else if (timed_out) state_d = ST_REPAIR;
            end
            ST_REMEAS: begin
                if (meas_done)      state_d = in_win ? ST_NEXT : ST_REPAIR;
                else if (timed_out) state_d = ST_REPAIR;
            end
            ST_REPAIR: begin
                if (rep_done)       state_d = ST_RECHECK;
                else if (timed_out) state_d = ST_REPLACE;
            end
            ST_RECHECK: begin
                if (meas_done)      state_d = in_win ? ST_NEXT : ST_REPLACE;
                else if (timed_out) state_d = ST_REPLACE;
            end
            ST_REPLACE: state_d = ST_NEXT;
            ST_NEXT:    state_d = (blk_q == LAST_BLK) ? ST_IDLE : ST_MEAS;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with block index and handshake wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && tick) begin
                blk_q <= '0;
            end else if (state_q == ST_NEXT && blk_q != LAST_BLK) begin
                blk_q <= blk_q + BLK_W'(1);
            end
            if (state_d != state_q) begin
                wait_q <= '0;
            end else if (any_req) begin
                wait_q <= wait_q + WAIT_W'(1);
            end
        end
    end
endmodule

// File: rtl/lrs_repair_seq_chk.sv
module lrs_repair_seq_chk #(
    parameter int TIMEOUT = 16,
    parameter int MAP_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_req,
    input logic             meas_done,
    input logic             adj_req,
    input logic             adj_done,
    input logic             rep_req,
    input logic             rep_done,
    input logic             sweep_busy,
    input logic [MAP_W-1:0] remap_tbl,
    input logic             spare_fault
);
    localparam int RUN_W = $clog2(TIMEOUT + 2) + 1;

    logic [2:0]       req_vec, prev_vec;
    logic [RUN_W-1:0] run_q;

    assign req_vec = {meas_req, adj_req, rep_req};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vec <= '0;
            run_q    <= '0;
        end else begin
            prev_vec <= req_vec;
            if (req_vec == '0)            run_q <= '0;
            else if (req_vec != prev_vec) run_q <= RUN_W'(1);
            else                          run_q <= run_q + RUN_W'(1);
        end
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_busy |-> (req_vec == 3'b000)); // R2
    AST_MEAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && meas_done) |=> !meas_req); // R9
    AST_ADJ_TO_REMEAS: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_req && adj_done) |=> meas_req); // R5
    AST_REP_TO_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_req && rep_done) |=> meas_req); // R6
    AST_REQ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(TIMEOUT)); // R9
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spare_fault |=> spare_fault); // R8
    AST_MAP_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remap_tbl) |-> ($past(sweep_busy) && sweep_busy)); // R7
endmodule

bind lrs_repair_seq lrs_repair_seq_chk #(.TIMEOUT(TIMEOUT), .MAP_W(MAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .meas_req(meas_req), .meas_done(meas_done),
    .adj_req(adj_req), .adj_done(adj_done),
    .rep_req(rep_req), .rep_done(rep_done),
    .sweep_busy(sweep_busy), .remap_tbl(remap_tbl), .spare_fault(spare_fault)
);

// File: tb/lrs_repair_seq_bench.sv
`timescale 1ns/1ps
module lrs_repair_seq_bench;
    localparam int TMO = 16;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period = '0;
    logic [11:0] win_lo = 12'd1000, win_hi = 12'd3000;
    logic        meas_req, adj_req, rep_req, sweep_busy, spare_fault;
    logic [3:0]  meas_idx, adj_idx, rep_idx;
    logic        meas_done = 1'b0, adj_done = 1'b0, rep_done = 1'b0;
    logic [11:0] meas_code = '0;
    logic [31:0] remap_tbl;

    always #2.5 clk = ~clk;

    lrs_repair_seq u_lrs_repair_seq (
        .clk(clk), .rst_n(rst_n), .period(period), .win_lo(win_lo), .win_hi(win_hi),
        .meas_req(meas_req), .meas_idx(meas_idx), .meas_done(meas_done), .meas_code(meas_code),
        .adj_req(adj_req), .adj_idx(adj_idx), .adj_done(adj_done),
        .rep_req(rep_req), .rep_idx(rep_idx), .rep_done(rep_done),
        .sweep_busy(sweep_busy), .remap_tbl(remap_tbl), .spare_fault(spare_fault)
    );

    int nvec = 0, nfail = 0, cyc = 0;
    bit running = 0;

    // reference model state: 0 idle,1 meas,2 adj,3 remeas,4 repair,5 recheck,6 replace,7 next
    int m_st = 0, m_blk = 0, m_wait = 0, m_per = 0, m_used = 0, m_sweeps = 0;
    bit m_fault = 0;
    int m_map [8];

    // responder scripting per physical index
    int codeq [12][$];
    int hang_m [12], hang_a [12], hang_r [12];
    int rc = 0;
    bit cur_hang = 0;
    logic [2:0] prev_rv = '0;
    bit seen8 = 0, seen5 = 0, track = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_pack();
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) v[i*4 +: 4] = 4'(m_map[i]);
        return v;
    endfunction

    task automatic model_step(input bit md, input bit ad, input bit rd, input int code);
        bit tick, pass, to;
        int nx;
        tick = (period != 0) && (m_per >= int'(period) - 1);
        pass = (code >= int'(win_lo)) && (code <= int'(win_hi));
        to   = (m_wait == TMO - 1);
        nx   = m_st;
        case (m_st)
            0: if (tick) nx = 1;
            1: if (md) nx = pass ? 7 : 2; else if (to) nx = 2;
            2: if (ad) nx = 3; else if (to) nx = 4;
            3: if (md) nx = pass ? 7 : 4; else if (to) nx = 4;
            4: if (rd) nx = 5; else if (to) nx = 6;
            5: if (md) nx = pass ? 7 : 6; else if (to) nx = 6;
            6: begin
                if (m_used < 4) begin m_map[m_blk] = 8 + m_used; m_used++; end
                else m_fault = 1;
                nx = 7;
            end
            default: nx = (m_blk == 7) ? 0 : 1;
        endcase
        if (m_st == 7 && m_blk == 7) m_sweeps++;
        if (m_st == 0 && tick) m_blk = 0;
        else if (m_st == 7 && m_blk != 7) m_blk++;
        if (nx != m_st) m_wait = 0;
        else if (m_st >= 1 && m_st <= 5) m_wait++;
        m_per = tick ? 0 : (m_per + 1) % 65536;
        m_st = nx;
    endtask

    always @(negedge clk) begin
        if (running) begin
            bit em, ea, er, md, ad, rd;
            int code, idx;
            logic [2:0] rv;
            em = (m_st == 1 || m_st == 3 || m_st == 5);
            ea = (m_st == 2);
            er = (m_st == 4);
            idx = m_map[m_blk];
            chk("R1 sweep_busy", 32'(sweep_busy), 32'(m_st != 0));
            chk("R3 meas_req", 32'(meas_req), 32'(em));
            chk("R4 adj_req", 32'(adj_req), 32'(ea));
            chk("R5 rep_req", 32'(rep_req), 32'(er));
            if (em) chk("R10 meas_idx", 32'(meas_idx), 32'(idx));
            if (ea) chk("R4 adj_idx", 32'(adj_idx), 32'(idx));
            if (er) chk("R5 rep_idx", 32'(rep_idx), 32'(idx));
            chk("R7 remap_tbl", remap_tbl, m_pack());
            chk("R8 spare_fault", 32'(spare_fault), 32'(m_fault));
            if (track && em && idx == 8) seen8 = 1;
            if (track && em && idx == 5) seen5 = 1;
            // responder
            rv = {em, ea, er};
            md = 0; ad = 0; rd = 0; code = 0;
            if (rv == 3'b000) rc = 0;
            else begin
                if (rv != prev_rv) begin
                    rc = 1;
                    cur_hang = 0;
                    if (em && hang_m[idx] > 0) begin cur_hang = 1; hang_m[idx]--; end
                    if (ea && hang_a[idx] > 0) begin cur_hang = 1; hang_a[idx]--; end
                    if (er && hang_r[idx] > 0) begin cur_hang = 1; hang_r[idx]--; end
                end else rc++;
                if (!cur_hang && rc == LAT) begin
                    md = em; ad = ea; rd = er;
                    if (em) code = (codeq[idx].size() > 0) ? codeq[idx].pop_front() : 2000;
                end
            end
            prev_rv = rv;
            meas_done = md; adj_done = ad; rep_done = rd; meas_code = 12'(code);
            model_step(md, ad, rd, code);
        end
    end

    task automatic wait_sweeps(input int n);
        int k = 0;
        while (m_sweeps < n && k < 20000) begin
            @(posedge clk);
            k++;
        end
        #1;
        if (m_sweeps < n) begin
            nvec++; nfail++;
            $display("FAIL R1 watchdog: sweeps actual=%0d expected=%0d", m_sweeps, n);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nvec++; nfail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_map[i] = i;
        for (int i = 0; i < 12; i++) begin hang_m[i] = 0; hang_a[i] = 0; hang_r[i] = 0; end
        repeat (4) @(negedge clk);
        #1;
        // R11 reset state
        chk("R11 busy", 32'(sweep_busy), 32'd0);
        chk("R11 reqs", 32'({meas_req, adj_req, rep_req}), 32'd0);
        chk("R11 remap", remap_tbl, 32'h76543210);
        chk("R11 fault", 32'(spare_fault), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1;
        // R1: period 0 gives no sweep
        repeat (40) @(posedge clk);
        #1;
        chk("R1 no sweep with period 0", 32'(m_sweeps), 32'd0);
        // Scenario: boundaries, adjust fix, repair fix, hard fail, hung drivers
        codeq[0].push_back(1000);
        codeq[1].push_back(3000);
        codeq[2].push_back(999);  codeq[2].push_back(2000);
        codeq[3].push_back(3001); codeq[3].push_back(3001); codeq[3].push_back(2000);
        codeq[5].push_back(0);    codeq[5].push_back(0);    codeq[5].push_back(0);
        hang_m[6] = 1; hang_a[6] = 1; hang_r[6] = 1;
        period = 16'd200;
        wait_sweeps(1);
        period = 16'd0;
        chk("R3 boundary blocks kept", 32'(remap_tbl[7:0]), 32'h10);
        chk("R4 adjust-fixed block kept", 32'(remap_tbl[11:8]), 32'd2);
        chk("R6 repair-fixed block kept", 32'(remap_tbl[15:12]), 32'd3);
        chk("R7 failed block on spare 8", 32'(remap_tbl[23:20]), 32'd8);
        chk("R9 timed-out block on spare 9", 32'(remap_tbl[27:24]), 32'd9);
        chk("R8 fault clear with spares left", 32'(spare_fault), 32'd0);
        // R2 and R10: short period, back-to-back sweeps
        repeat (5) @(posedge clk);
        #1;
        track = 1;
        period = 16'd5;
        wait_sweeps(3);
        period = 16'd0;
        track = 0;
        chk("R10 remapped block measured at spare", 32'(seen8), 32'd1);
        chk("R10 old index unused", 32'(seen5), 32'd0);
        chk("R2 tables stable over clean sweeps", remap_tbl[27:20], 8'h98);
        // R8: exhaust spares
        repeat (5) @(posedge clk);
        #1;
        for (int j = 0; j < 3; j++) begin
            codeq[0].push_back(0); codeq[1].push_back(0); codeq[4].push_back(0);
        end
        period = 16'd50;
        wait_sweeps(4);
        period = 16'd0;
        chk("R7 block 0 on spare 10", 32'(remap_tbl[3:0]), 32'd10);
        chk("R7 block 1 on spare 11", 32'(remap_tbl[7:4]), 32'd11);
        chk("R8 block 4 unchanged", 32'(remap_tbl[19:16]), 32'd4);
        chk("R8 fault raised", 32'(spare_fault), 32'd1);
        repeat (10) @(posedge clk);
        #1;
        chk("R8 fault sticky", 32'(spare_fault), 32'd1);
        running = 0;
        finish_run();
    end
endmodule